// File: doc/BRIEF.md
# Weekly Minute Alarm Comparator

This block watches the time of day that a calendar counter supplies and raises an interrupt when it reaches a programmed alarm. Software programs three alarm fields and a control register through a small register port. The fields are an alarm minute in BCD, an alarm hour in BCD, and a seven-bit weekday mask. The calendar counter supplies the current minute, hour and weekday. It also gives a one-cycle `minTick` strobe in the cycle where a new minute begins, which is when the seconds roll over to 00.

The comparison happens only on that strobe, so the alarm has one-minute resolution and each matching minute produces exactly one event. Any number of weekdays can be selected at once. A match sets a sticky flag. Software clears the flag by writing one to the clear bit. The interrupt output is that flag gated by the enable bit, and it is a level signal.

Top module: `minute_alarm`

## Requirements
- R1: After reset, the minute, hour, mask, enable and flag registers are all zero, every read address returns 0, and `irq` is low.
- R2: Register address 0 holds the alarm minute and address 1 holds the alarm hour. Both are stored as full 8-bit BCD and read back unchanged. Address 2 holds the weekday mask in bits 6:0, and bit 7 always reads 0. Address 3 is the control register: bit 0 is the enable and reads back, bit 1 reads as the alarm flag, and writing 1 to bit 1 clears the flag. Reads are combinational from `rdAddr`.
- R3: A `minTick` cycle sets the flag, visible from the next cycle, when all three conditions hold: `curMin` equals the alarm minute, `curHour` equals the alarm hour, and mask bit `curDay` is 1.
- R4: Without `minTick`, a matching time never sets the flag. Seconds play no part in the match.
- R5: A difference in the minute, the hour or the selected weekday prevents the flag from being set.
- R6: Several mask bits may be set, and each selected weekday matches. A `curDay` value of 7 never matches.
- R7: The flag stays set until a control write with bit 1 at 1. A control write with bit 1 at 0 leaves the flag unchanged.
- R8: When a match and a clearing write happen in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when the flag and the enable are both 1. The flag sets even while the enable is 0, so a later enable raises `irq` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| minTick | input | 1 | One-cycle strobe at the start of each new minute |
| curMin | input | 8 | Current minute, BCD |
| curHour | input | 8 | Current hour, BCD, 24-hour format |
| curDay | input | 3 | Current weekday, 0 to 6 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Register read data |
| irq | output | 1 | Level alarm interrupt |

## Verification
The assertions assume that `minTick` is at most a single-cycle strobe. They also assume that the only way the flag can be cleared is a control write, so every fall of the flag must trace back to one.

The stimulus keeps `curDay` within 0 to 7. It drives `minTick` and writes as isolated single-cycle events. Half of the random ticks are steered onto the programmed minute and hour, so that matches, weekday misses and clears happening in the same cycle as a tick all occur often.

// File: rtl/minute_alarm_pkg.sv
package minute_alarm_pkg;

  typedef enum logic [1:0] {
    ADDR_MIN  = 2'd0,
    ADDR_HOUR = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_CTL  = 2'd3
  } almAddr_t;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_CLR_BIT = 1;

  typedef struct packed {
    logic ldMin;
    logic ldHour;
    logic ldMask;
    logic ldCtl;
    logic clrFlag;
    logic setFlag;
  } almStrobe_t;

endpackage

// File: rtl/minute_alarm_ctrl.sv
module minute_alarm_ctrl
  import minute_alarm_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic       clrBit,
  input  logic       minTick,
  input  logic       hit,
  output almStrobe_t strobe
);

  always_comb begin
    strobe         = '0;
    strobe.ldMin   = wrEn && (wrAddr == ADDR_MIN);
    strobe.ldHour  = wrEn && (wrAddr == ADDR_HOUR);
    strobe.ldMask  = wrEn && (wrAddr == ADDR_MASK);
    strobe.ldCtl   = wrEn && (wrAddr == ADDR_CTL);
    strobe.clrFlag = strobe.ldCtl && clrBit;
    strobe.setFlag = minTick && hit;
  end

endmodule

// File: rtl/minute_alarm_dp.sv
module minute_alarm_dp
  import minute_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DAYS   = 7,
  parameter int DAY_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  almStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DAY_W-1:0]  curDay,
  input  logic [1:0]        rdAddr,
  output logic              hit,
  output logic              alarmFlag,
  output logic              alarmEn,
  output logic              irq,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] almMin, almHour;
  logic [DAYS-1:0]   almMask;
  logic [DAYS-1:0]   dayMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      almMin    <= '0;
      almHour   <= '0;
      almMask   <= '0;
      alarmEn   <= 1'b0;
      alarmFlag <= 1'b0;
    end else begin
      if (strobe.ldMin)  almMin  <= wrData;
      if (strobe.ldHour) almHour <= wrData;
      if (strobe.ldMask) almMask <= wrData[DAYS-1:0];
      if (strobe.ldCtl)  alarmEn <= wrData[CTL_EN_BIT];
      if (strobe.setFlag)      alarmFlag <= 1'b1;
      else if (strobe.clrFlag) alarmFlag <= 1'b0;
    end
  end

  for (genvar d = 0; d < DAYS; d++) begin : g_day
    assign dayMatch[d] = almMask[d] && (curDay == DAY_W'(d));
  end

  assign hit = (curMin == almMin) && (curHour == almHour) && (|dayMatch);
  assign irq = alarmFlag && alarmEn;

  always_comb begin
    unique case (rdAddr)
      ADDR_MIN:  rdData = almMin;
      ADDR_HOUR: rdData = almHour;
      ADDR_MASK: rdData = {{(DATA_W-DAYS){1'b0}}, almMask};
      default:   rdData = {{(DATA_W-2){1'b0}}, alarmFlag, alarmEn};
    endcase
  end

endmodule

// File: rtl/minute_alarm.sv
module minute_alarm
  import minute_alarm_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int DAYS   = 7,
  localparam int DAY_W  = $clog2(DAYS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              minTick,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DAY_W-1:0]  curDay,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  almStrobe_t strobe;
  logic       hit;
  logic       alarmFlag;
  logic       alarmEn;

  minute_alarm_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .clrBit  (wrData[CTL_CLR_BIT]),
    .minTick (minTick),
    .hit     (hit),
    .strobe  (strobe)
  );

  minute_alarm_dp #(.DATA_W(DATA_W), .DAYS(DAYS), .DAY_W(DAY_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .curMin    (curMin),
    .curHour   (curHour),
    .curDay    (curDay),
    .rdAddr    (rdAddr),
    .hit       (hit),
    .alarmFlag (alarmFlag),
    .alarmEn   (alarmEn),
    .irq       (irq),
    .rdData    (rdData)
  );

endmodule

// File: rtl/minute_alarm_chk.sv
module minute_alarm_chk #(
  parameter int DATA_W = 8,
  parameter int DAYS   = 7,
  parameter int DAY_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              minTick,
  input logic [DAY_W-1:0]  curDay,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              alarmFlag,
  input logic              irq
);

  // R4: the flag can only rise right after a minute tick
  a_r4_set_only_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(minTick));

  // R7: the flag only falls after a clearing control write
  a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarmFlag) |-> $past(wrEn && wrAddr == 2'd3 && wrData[1]));

  // R7: a clearing write with no tick leaves the flag low
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3 && wrData[1] && !minTick) |=> !alarmFlag);

  // R9: clearing the enable silences the interrupt
  a_r9_disable_masks: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3 && !wrData[0]) |=> !irq);

  // R6: an out-of-range weekday never sets the flag
  a_r6_day7_no_match: assert property (@(posedge clk) disable iff (!rstN)
    (minTick && curDay >= DAY_W'(DAYS) && !alarmFlag) |=> !alarmFlag);

endmodule

bind minute_alarm minute_alarm_chk #(.DATA_W(DATA_W), .DAYS(DAYS), .DAY_W(DAY_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .minTick   (minTick),
  .curDay    (curDay),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .alarmFlag (alarmFlag),
  .irq       (irq)
);

// File: tb/minute_alarm_test.sv
`timescale 1ns/1ps
module minute_alarm_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       minTick = 1'b0;
  logic [7:0] curMin = '0, curHour = '0;
  logic [2:0] curDay = '0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = 2'd3;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] eMin = '0, eHour = '0;
  logic [6:0] eMask = '0;
  logic       eEn = 1'b0, eFlag = 1'b0;

  always #2.5 clk = ~clk;

  minute_alarm uut (
    .clk(clk), .rstN(rstN), .minTick(minTick), .curMin(curMin),
    .curHour(curHour), .curDay(curDay), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  function automatic logic [7:0] bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic modelHit(logic [7:0] m, logic [7:0] h, logic [2:0] d);
    return (m == eMin) && (h == eHour) && (d < 3'd7) && eMask[d];
  endfunction

  task automatic expect8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkState(string tag);
    rdAddr = 2'd3;
    #1;
    expect8(tag, {6'b0, rdData[1:0]}, {6'b0, eFlag, eEn});
    expect8(tag, {7'b0, irq}, {7'b0, eFlag & eEn});
  endtask

  // one cycle with optional tick and optional write; model updated alongside
  task automatic step(string tag, bit t, logic [7:0] m, logic [7:0] h, logic [2:0] d,
                      bit w, logic [1:0] a, logic [7:0] v);
    logic nFlag;
    minTick = t; curMin = m; curHour = h; curDay = d;
    wrEn = w; wrAddr = a; wrData = v;
    nFlag = (t && modelHit(m, h, d)) || (eFlag && !(w && a == 2'd3 && v[1]));
    if (w) begin
      case (a)
        2'd0: eMin = v;
        2'd1: eHour = v;
        2'd2: eMask = v[6:0];
        default: eEn = v[0];
      endcase
    end
    eFlag = nFlag;
    @(posedge clk);
    @(negedge clk);
    minTick = 1'b0; wrEn = 1'b0;
    checkState(tag);
  endtask

  task automatic wr(string tag, logic [1:0] a, logic [7:0] v);
    step(tag, 1'b0, 8'h00, 8'h00, 3'd0, 1'b1, a, v);
  endtask

  task automatic tick(string tag, logic [7:0] m, logic [7:0] h, logic [2:0] d);
    step(tag, 1'b1, m, h, d, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic readReg(string tag, logic [1:0] a, logic [7:0] exp);
    rdAddr = a;
    #1;
    expect8(tag, rdData, exp);
    rdAddr = 2'd3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    for (int i = 0; i < 4; i++) readReg("R1", 2'(i), 8'h00);
    expect8("R1", {7'b0, irq}, 8'h00);

    // R2 register map
    wr("R2", 2'd0, 8'h45);
    wr("R2", 2'd1, 8'h23);
    wr("R2", 2'd2, 8'hFF);
    readReg("R2", 2'd0, 8'h45);
    readReg("R2", 2'd1, 8'h23);
    readReg("R2", 2'd2, 8'h7F);
    wr("R2", 2'd3, 8'h03);
    readReg("R2", 2'd3, 8'h01);

    // R3 match
    tick("R3", 8'h45, 8'h23, 3'd3);
    // R7 sticky, non-clearing write keeps flag, clearing write drops it
    wr("R7", 2'd3, 8'h01);
    tick("R7", 8'h46, 8'h23, 3'd3);
    wr("R7", 2'd3, 8'h03);

    // R4 matching time without tick
    step("R4", 1'b0, 8'h45, 8'h23, 3'd3, 1'b0, 2'd0, 8'h00);

    // R5 each field mismatch
    tick("R5", 8'h46, 8'h23, 3'd3);
    tick("R5", 8'h45, 8'h22, 3'd3);
    wr("R5", 2'd2, 8'h04);
    tick("R5", 8'h45, 8'h23, 3'd3);
    tick("R5", 8'h45, 8'h23, 3'd2);
    wr("R5", 2'd3, 8'h03);

    // R6 multiple weekdays, day 7 never
    wr("R6", 2'd2, 8'h41);
    tick("R6", 8'h45, 8'h23, 3'd6);
    wr("R6", 2'd3, 8'h03);
    tick("R6", 8'h45, 8'h23, 3'd0);
    wr("R6", 2'd3, 8'h03);
    wr("R6", 2'd2, 8'h7F);
    tick("R6", 8'h45, 8'h23, 3'd7);

    // R8 set wins over simultaneous clear
    step("R8", 1'b1, 8'h45, 8'h23, 3'd1, 1'b1, 2'd3, 8'h03);

    // R9 gating
    wr("R9", 2'd3, 8'h00);
    wr("R9", 2'd3, 8'h02);
    tick("R9", 8'h45, 8'h23, 3'd4);
    wr("R9", 2'd3, 8'h01);

    // random mix, R3 R5 R7 R9
    for (int i = 0; i < 600; i++) begin
      int sel;
      sel = int'($urandom % 10);
      if (sel == 0) begin
        logic [1:0] a;
        a = 2'($urandom % 3);
        wr("R2", a, (a == 2'd1) ? bcd(int'($urandom % 24)) :
                    (a == 2'd0) ? bcd(int'($urandom % 60)) : 8'($urandom));
      end else if (sel <= 2) begin
        wr("R7", 2'd3, 8'($urandom % 4));
      end else if (sel <= 7) begin
        logic [7:0] m, h;
        bit near;
        near = ($urandom % 2) == 0;
        m = near ? eMin  : bcd(int'($urandom % 60));
        h = near ? eHour : bcd(int'($urandom % 24));
        step("R3", 1'b1, m, h, 3'($urandom % 8), ($urandom % 4) == 0, 2'd3,
             8'($urandom % 4));
      end else begin
        step("R9", 1'b0, eMin, eHour, 3'($urandom % 7), 1'b0, 2'd0, 8'h00);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule